// File: doc/BRIEF.md
# Strobed Bus Master Sequencer

This block turns a single read or write request into one complete access on a 16-bit data, 24-bit address bus. The bus uses an address strobe, two byte-lane data strobes and a data-acknowledge handshake. The block runs on a clock whose period is one half-cycle of the processor clock, so every count below is in half-cycles.

An access is built from fixed-length microcycles. An address phase of 5 clocks holds the address strobe asserted. Wait microcycles of 2 clocks each are then added for as long as the acknowledge stays absent. A data phase of 3 clocks follows, with the byte-lane strobes asserted. One clock after all strobes release, the block raises a done pulse, and on a read it presents the captured word. The requester offers a new access only while the block reports ready.

Top module: `strobe_bus_master`

## Requirements
- R1: After reset, and whenever no access is in progress, `as_n`, `uds_n` and `lds_n` are high, `data_oe` is low, `rsp_done` is low and `req_ready` is high.
- R2: `as_n` is held low for the first 5 clocks of an access before any data strobe goes low. Over the whole access `as_n` stays low for 5 + 2·W + 3 clocks, where W is the number of wait microcycles.
- R3: `dtack_n` is sampled on the last clock of the address phase and on the last clock of each 2-clock wait microcycle. W is the number of such samples that find `dtack_n` high. Data strobes never go low unless `dtack_n` was low at the sample just before.
- R4: The data strobes are low for exactly 3 consecutive clocks per access.
- R5: For a word access (`req_word`=1) both `uds_n` and `lds_n` go low. For a byte access, `req_addr[0]`=0 selects `uds_n` only and `req_addr[0]`=1 selects `lds_n` only.
- R6: `bus_rw` is 1 for a read (`req_read`=1) and 0 for a write.
- R7: `bus_addr` equals `req_addr[23:1]`. Bit 0 and bits 31..24 of `req_addr` have no effect on the bus address.
- R8: `bus_fc` carries `req_fc` unchanged: bit 0 = data space, bit 1 = program space, bit 2 = supervisor mode, and the value 7 is an interrupt acknowledge.
- R9: On a write, `data_oe` is high and `data_out` equals the request's write data during exactly the 3 data-phase clocks. On a read, `data_oe` stays low.
- R10: `rsp_done` is high for exactly one clock: the first clock after `as_n` returns high. On a read, `rsp_rdata` then holds the value `data_in` had on the last data-phase clock.
- R11: While an access is in progress `req_ready` is low and requests are ignored. `bus_addr`, `bus_fc` and `bus_rw` stay stable for the whole time `as_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1 = read, 0 = write |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write data |
| req_fc | input | 3 | Function code for the access |
| req_ready | output | 1 | Idle, a request is accepted |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| bus_addr | output | 23 | Address bits 23..1 |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper byte strobe, active low |
| lds_n | output | 1 | Lower byte strobe, active low |
| bus_rw | output | 1 | High = read, low = write |
| bus_fc | output | 3 | Function-code lines |
| data_out | output | 16 | Write data to the bus |
| data_oe | output | 1 | Drive enable for `data_out` |
| data_in | input | 16 | Read data from the bus |
| dtack_n | input | 1 | Data acknowledge, active low |

## Verification
A wrong phase counter shows up as a wrong count of clocks with `as_n` low, or with the data strobes low. The error is visible at the end of the very first access. A wrong handling of the acknowledge sample moves the data phase by a whole wait microcycle, which changes the total strobe length by 2. The bench's responder delays the acknowledge by several amounts, so an off-by-one in the sample point changes the count for at least one of them. Lane, direction or address latching errors appear in the first data-phase clock of the affected access. A late capture or a misplaced done pulse is caught in the clock right after `as_n` rises.

// File: rtl/strobe_bus_master.sv
module strobe_bus_master #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int AS_HC   = 5,
  parameter int WAIT_HC = 2,
  parameter int DS_HC   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_read,
  input  logic          req_word,
  input  logic [31:0]   req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [2:0]    req_fc,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-2:0] bus_addr,
  output logic          as_n,
  output logic          uds_n,
  output logic          lds_n,
  output logic          bus_rw,
  output logic [2:0]    bus_fc,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic [DW-1:0] data_in,
  input  logic          dtack_n
);
  localparam int MAXL = (AS_HC > DS_HC) ? ((AS_HC > WAIT_HC) ? AS_HC : WAIT_HC)
                                        : ((DS_HC > WAIT_HC) ? DS_HC : WAIT_HC);
  localparam int CW = $clog2(MAXL + 1);
  localparam logic [CW-1:0] AS_LAST = CW'(AS_HC - 1);
  localparam logic [CW-1:0] WT_LAST = CW'(WAIT_HC - 1);
  localparam logic [CW-1:0] DS_LAST = CW'(DS_HC - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WAIT, S_DATA, S_DONE} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic up_q, lo_q;
  logic unused_bits;

  assign unused_bits = ^{req_addr[31:AW], req_addr[0]};

  assign req_ready = (st == S_IDLE);
  assign rsp_done  = (st == S_DONE);
  assign as_n      = !(st == S_ADDR || st == S_WAIT || st == S_DATA);
  assign uds_n     = !(st == S_DATA && up_q);
  assign lds_n     = !(st == S_DATA && lo_q);
  assign data_oe   = (st == S_DATA) && !bus_rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      up_q      <= 1'b0;
      lo_q      <= 1'b0;
      bus_addr  <= '0;
      bus_fc    <= '0;
      bus_rw    <= 1'b1;
      data_out  <= '0;
      rsp_rdata <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          st       <= S_ADDR;
          cnt      <= '0;
          bus_addr <= req_addr[AW-1:1];
          bus_fc   <= req_fc;
          bus_rw   <= req_read;
          data_out <= req_wdata;
          up_q     <= req_word || !req_addr[0];
          lo_q     <= req_word ||  req_addr[0];
        end
        S_ADDR: if (cnt == AS_LAST) begin
          st  <= dtack_n ? S_WAIT : S_DATA;
          cnt <= '0;
        end
        S_WAIT: if (cnt == WT_LAST) begin
          st  <= dtack_n ? S_WAIT : S_DATA;
          cnt <= '0;
        end
        S_DATA: if (cnt == DS_LAST) begin
          st <= S_DONE;
          if (bus_rw) rsp_rdata <= data_in;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4, R2: a data strobe is only ever asserted inside an address-strobed access
  p_ds_inside_as_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(uds_n && lds_n) |-> !as_n);

  // R10: completion only once every strobe has released
  p_done_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (as_n && uds_n && lds_n && !data_oe));

  // R10: done lasts one clock
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R11: address, function code and direction hold while strobed
  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && $past(!as_n)) |-> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_rw)));

  // R9: bus driven only for writes inside the data phase
  p_oe_write_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!bus_rw && !(uds_n && lds_n)));

  // R3: the data phase opens only after an acknowledge was sampled
  p_ds_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uds_n && lds_n) |-> $past(!dtack_n));

  // R11: no acceptance while busy
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> !req_ready);
endmodule

// File: tb/strobe_bus_master_test.sv
module strobe_bus_master_test;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic        rd;
    logic        word;
    logic [31:0] addr;
    logic [15:0] data;
    logic [2:0]  fc;
    int          delay;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, req_word = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  req_fc = '0;
  logic req_ready, rsp_done, as_n, uds_n, lds_n, bus_rw, data_oe;
  logic [15:0] rsp_rdata, data_out, data_in;
  logic [22:0] bus_addr;
  logic [2:0]  bus_fc;
  logic dtack_n = 1'b1;

  int checks = 0, fails = 0;
  item_t exp_q[$];
  item_t cur;
  int cur_delay = 0;
  int asc = 0;
  bit in_acc = 0;
  int as_cnt = 0, ds_cnt = 0;
  bit first_ds = 0;
  logic [15:0] rd_pat = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_bus_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata), .req_fc(req_fc),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .bus_rw(bus_rw),
    .bus_fc(bus_fc), .data_out(data_out), .data_oe(data_oe), .data_in(data_in),
    .dtack_n(dtack_n)
  );

  assign data_in = (!uds_n || !lds_n) ? rd_pat : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // responder: acknowledge after cur_delay clocks of address strobe
  always @(negedge clk) begin
    if (!as_n) asc = asc + 1; else asc = 0;
    dtack_n = !(!as_n && asc >= cur_delay);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!as_n) begin
        if (!in_acc) begin
          in_acc = 1; as_cnt = 0; ds_cnt = 0; first_ds = 1;
          cur = exp_q.pop_front();
          chk(bus_addr == cur.addr[23:1], "R7 address", bus_addr, cur.addr[23:1]);
          chk(bus_fc == cur.fc, "R8 function code", bus_fc, cur.fc);
          chk(bus_rw == cur.rd, "R6 direction", bus_rw, cur.rd);
          chk(req_ready == 1'b0, "R11 ready while busy", req_ready, 0);
        end
        as_cnt++;
        if (!uds_n || !lds_n) begin
          ds_cnt++;
          if (first_ds) begin
            first_ds = 0;
            chk(as_cnt == 5 + 2*((cur.delay > 5) ? (cur.delay - 4)/2 : 0) + 1,
                "R3 data phase start", as_cnt,
                5 + 2*((cur.delay > 5) ? (cur.delay - 4)/2 : 0) + 1);
            chk(uds_n == !(cur.word || !cur.addr[0]), "R5 upper lane", uds_n, !(cur.word || !cur.addr[0]));
            chk(lds_n == !(cur.word ||  cur.addr[0]), "R5 lower lane", lds_n, !(cur.word || cur.addr[0]));
          end
          if (cur.rd) chk(data_oe == 0, "R9 no drive on read", data_oe, 0);
          else chk(data_oe == 1 && data_out == cur.data, "R9 write data", data_out, cur.data);
        end else begin
          chk(data_oe == 0, "R9 idle drive", data_oe, 0);
        end
      end else if (in_acc) begin
        in_acc = 0;
        chk(as_cnt == 8 + 2*((cur.delay > 5) ? (cur.delay - 4)/2 : 0), "R2 strobe length",
            as_cnt, 8 + 2*((cur.delay > 5) ? (cur.delay - 4)/2 : 0));
        chk(ds_cnt == 3, "R4 data strobe length", ds_cnt, 3);
        chk(rsp_done == 1, "R10 done after strobes", rsp_done, 1);
        if (cur.rd) chk(rsp_rdata == cur.data, "R10 read data", rsp_rdata, cur.data);
      end else begin
        chk(rsp_done == 0, "R10 done single", rsp_done, 0);
      end
    end
  end

  task automatic issue(input logic rd, input logic word, input logic [31:0] addr,
                       input logic [15:0] data, input logic [2:0] fc, input int delay);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.rd = rd; it.word = word; it.addr = addr; it.data = data; it.fc = fc; it.delay = delay;
    exp_q.push_back(it);
    cur_delay = delay;
    rd_pat = data;
    req_valid = 1; req_read = rd; req_word = word; req_addr = addr; req_wdata = data; req_fc = fc;
    @(negedge clk);
    // garbage while busy must be ignored
    req_read = !rd; req_word = !word; req_addr = ~addr; req_wdata = ~data; req_fc = ~fc;
    while (!rsp_done) @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(as_n && uds_n && lds_n && !data_oe && !rsp_done && req_ready, "R1 reset state",
        {as_n, uds_n, lds_n, data_oe, rsp_done, req_ready}, 6'b111001);
    rst_n = 1;
    @(negedge clk);
    chk(as_n && req_ready && !rsp_done, "R1 idle after reset", {as_n, req_ready, rsp_done}, 3'b110);
    issue(1, 1, 32'h0000_1234, 16'hA55A, 3'd1, 0);
    issue(0, 0, 32'h0000_2001, 16'h00C3, 3'd5, 6);
    issue(1, 0, 32'h0000_3000, 16'h7E00, 3'd2, 9);
    issue(0, 1, 32'hFF12_3456, 16'hBEEF, 3'd6, 5);
    issue(1, 0, 32'h0000_4443, 16'h0091, 3'd1, 8);
    issue(1, 1, 32'hABFF_FFFF, 16'h1357, 3'd7, 7);
    issue(0, 0, 32'h0080_0000, 16'h4200, 3'd5, 12);
    repeat (4) @(negedge clk);
    chk(as_n && req_ready && exp_q.size() == 0, "R1 idle at end", {as_n, req_ready}, 2'b11);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule